// File: doc/BRIEF.md
# ATA PIO and Multiword DMA Strobe Controller

This block is the host-side engine for a 16-bit parallel disk bus. A host presents one request at a time: read or write, a register address, a choice of chip select, and whether the transfer is a register (PIO) cycle or a multiword DMA data word. The engine then sequences the bus. It asserts the selection, waits a programmed setup time, and drives the read or write strobe low for a programmed minimum width. It then releases the strobe and waits a programmed recovery time before it reports completion.

In PIO cycles the device is addressed through one of two active-low chip selects plus three address lines. It may stretch the strobe by holding IORDY low. In DMA cycles the device is addressed by the active-low DMA acknowledge alone, and IORDY plays no part. A DMA request can be one word of a longer burst, and the acknowledge stays asserted between the words of that burst. Read data is taken at the moment the read strobe rises. Write data is held on the bus past the rising edge of the write strobe. A PIO cycle that IORDY keeps stuck is cut off by a timeout and reported as an error.

Top module: `ata_pio_dma_ctl`

## Requirements
- R1: While reset is held and afterwards until a request arrives, both strobes, both chip selects and the DMA acknowledge are high, the data bus is not driven, and ack and err are low.
- R2: A PIO request drives the selects for the whole cycle up to the ack clock. req_cs=0 selects cs0_n and req_cs=1 selects cs1_n, and the other select stays high. da carries req_addr and dack_n stays high.
- R3: Timing counts run in clocks, and a count of zero acts as one. Selection precedes the strobe by cfg_setup clocks. With IORDY high the strobe is low for exactly cfg_active clocks. After strobe release, cfg_recov clocks pass with the selection still held. ack comes in the following clock.
- R4: On a read, rdata in the ack clock equals the dd_in value present during the last clock in which dior_n was low. dd_oe stays low for the whole read cycle.
- R5: On a write, diow_n is the only strobe used. dd_oe is high and dd_out equals req_wdata from the first setup clock through the last recovery clock, which includes the clocks after diow_n rises.
- R6: In a PIO cycle IORDY passes through a two-flop synchronizer. The strobe is released at the later of two edges: the edge ending the minimum width, and the second clock edge after the first edge that samples IORDY high.
- R7: A DMA request (req_dma=1) keeps both chip selects high, drives da to zero and asserts dack_n low from setup through recovery. IORDY has no effect on its strobe width.
- R8: A DMA word with req_last=0 keeps dack_n low after its ack until the next DMA request. A DMA word with req_last=1 releases dack_n in its ack clock.
- R9: If a PIO strobe has been low for 1024 clocks without release, it is released. The cycle completes with err high in the ack clock. A cycle that ends normally shows err low with its ack.
- R10: ack is high for exactly one clock per accepted request, and a request held high through that clock is not accepted a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_setup | input | 8 | Setup clocks before strobe (0 acts as 1) |
| cfg_active | input | 8 | Minimum strobe-low clocks (0 acts as 1) |
| cfg_recov | input | 8 | Recovery clocks after strobe release (0 acts as 1) |
| req | input | 1 | Request, held until ack |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_dma | input | 1 | 1 = DMA data word, 0 = PIO register cycle |
| req_cs | input | 1 | PIO chip-select choice: 0 = cs0_n, 1 = cs1_n |
| req_last | input | 1 | DMA: last word of the burst |
| req_addr | input | 3 | PIO register address |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Captured read word, valid with ack |
| err | output | 1 | Timeout flag, valid with ack |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| cs0_n | output | 1 | Chip select 0, active low |
| cs1_n | output | 1 | Chip select 1, active low |
| da | output | 3 | Device address lines |
| dack_n | output | 1 | DMA acknowledge, active low |
| dd_out | output | 16 | Data bus drive value |
| dd_oe | output | 1 | Data bus output enable |
| dd_in | input | 16 | Data bus sampled value |
| iordy | input | 1 | Device ready, asynchronous |

## Verification
The bench changes dd_in on every clock of the read strobe, so a design that samples one clock early or late returns the wrong word. On writes it checks that the bus is still driven after diow_n rises, which catches a design that drops dd_oe together with the strobe. It raises IORDY at a chosen point in the strobe and expects the width to be extended by exactly the synchronizer delay, and it expects DMA words to ignore a low IORDY. Further cases cover a three-word DMA burst, where dack_n must stay low between words and drop only after the last one, zero-valued timing counts, and a stuck IORDY. A wrong timeout would hang, give the wrong width, or complete without err.

// File: rtl/ata_pio_dma_ctl.sv
module ata_pio_dma_ctl #(
  parameter int DW       = 16,
  parameter int AW       = 3,
  parameter int CW       = 8,
  parameter int TMO_CLKS = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_active,
  input  logic [CW-1:0] cfg_recov,
  input  logic          req,
  input  logic          req_wr,
  input  logic          req_dma,
  input  logic          req_cs,
  input  logic          req_last,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic          dior_n,
  output logic          diow_n,
  output logic          cs0_n,
  output logic          cs1_n,
  output logic [AW-1:0] da,
  output logic          dack_n,
  output logic [DW-1:0] dd_out,
  output logic          dd_oe,
  input  logic [DW-1:0] dd_in,
  input  logic          iordy
);
  localparam int TW = $clog2(TMO_CLKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ACTV, S_RECV, S_GAP} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [TW-1:0] tcnt;
  logic          wr_q, dma_q, cs_q, last_q, dack_q, tmo_hit;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          ior_m, ior_s;

  wire [CW-1:0] s_min = (cfg_setup  == '0) ? CW'(1) : cfg_setup;
  wire [CW-1:0] a_min = (cfg_active == '0) ? CW'(1) : cfg_active;
  wire [CW-1:0] r_min = (cfg_recov  == '0) ? CW'(1) : cfg_recov;

  wire strobe = (st == S_ACTV);
  wire sel    = (st == S_SETUP) || (st == S_ACTV) || (st == S_RECV);
  wire pio    = sel && !dma_q;
  wire take   = req && !ack && ((st == S_IDLE) || (st == S_GAP && req_dma));
  wire done_ok  = (cnt >= a_min) && (dma_q || ior_s);
  wire done_tmo = !dma_q && (tcnt == TW'(TMO_CLKS - 1));

  assign dior_n = !(strobe && !wr_q);
  assign diow_n = !(strobe && wr_q);
  assign cs0_n  = !(pio && !cs_q);
  assign cs1_n  = !(pio && cs_q);
  assign da     = pio ? addr_q : '0;
  assign dack_n = !dack_q;
  assign dd_oe  = sel && wr_q;
  assign dd_out = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ior_m <= 1'b0;
      ior_s <= 1'b0;
    end else begin
      ior_m <= iordy;
      ior_s <= ior_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      tcnt    <= '0;
      wr_q    <= 1'b0;
      dma_q   <= 1'b0;
      cs_q    <= 1'b0;
      last_q  <= 1'b0;
      dack_q  <= 1'b0;
      tmo_hit <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      ack     <= 1'b0;
      err     <= 1'b0;
    end else begin
      ack <= 1'b0;
      err <= 1'b0;
      case (st)
        S_IDLE, S_GAP: begin
          if (take) begin
            wr_q    <= req_wr;
            dma_q   <= req_dma;
            cs_q    <= req_cs;
            last_q  <= req_last;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            dack_q  <= req_dma;
            cnt     <= CW'(1);
            st      <= S_SETUP;
          end else if (st == S_GAP && req && !ack) begin
            dack_q <= 1'b0;
            st     <= S_IDLE;
          end
        end
        S_SETUP: begin
          if (cnt >= s_min) begin
            cnt  <= CW'(1);
            tcnt <= '0;
            st   <= S_ACTV;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_ACTV: begin
          if (done_ok || done_tmo) begin
            if (!wr_q) rdata <= dd_in;
            tmo_hit <= !done_ok;
            cnt     <= CW'(1);
            st      <= S_RECV;
          end else begin
            if (cnt < a_min) cnt <= cnt + CW'(1);
            tcnt <= tcnt + TW'(1);
          end
        end
        S_RECV: begin
          if (cnt >= r_min) begin
            ack <= 1'b1;
            err <= tmo_hit;
            if (dma_q && !last_q) begin
              st <= S_GAP;
            end else begin
              dack_q <= 1'b0;
              st     <= S_IDLE;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ata_pio_dma_ctl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          err,
  input logic          dior_n,
  input logic          diow_n,
  input logic          cs0_n,
  input logic          cs1_n,
  input logic          dack_n,
  input logic          dd_oe,
  input logic [DW-1:0] dd_out
);
  AST_ONE_STROBE:   assert property (@(posedge clk) disable iff (!rst_n) !(!dior_n && !diow_n)); // R5
  AST_ONE_CS:       assert property (@(posedge clk) disable iff (!rst_n) !(!cs0_n && !cs1_n)); // R2
  AST_STROBE_SEL:   assert property (@(posedge clk) disable iff (!rst_n) (!dior_n || !diow_n) |-> (!cs0_n || !cs1_n || !dack_n)); // R2
  AST_DMA_NO_CS:    assert property (@(posedge clk) disable iff (!rst_n) !dack_n |-> (cs0_n && cs1_n)); // R7
  AST_READ_NO_OE:   assert property (@(posedge clk) disable iff (!rst_n) !dior_n |-> !dd_oe); // R4
  AST_WRITE_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) $rose(diow_n) |-> (dd_oe && $stable(dd_out))); // R5
  AST_ACK_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R10
  AST_ACK_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n) ack |-> (dior_n && diow_n && cs0_n && cs1_n)); // R3
  AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n) err |-> ack); // R9
endmodule

bind ata_pio_dma_ctl ata_pio_dma_ctl_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ack(ack), .err(err), .dior_n(dior_n), .diow_n(diow_n),
  .cs0_n(cs0_n), .cs1_n(cs1_n), .dack_n(dack_n), .dd_oe(dd_oe), .dd_out(dd_out)
);

// File: tb/ata_pio_dma_ctl_tb.sv
module ata_pio_dma_ctl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cfg_setup = 8'd1, cfg_active = 8'd1, cfg_recov = 8'd1;
  logic req = 0, req_wr = 0, req_dma = 0, req_cs = 0, req_last = 0;
  logic [2:0] req_addr = '0;
  logic [15:0] req_wdata = '0, dd_in = '0;
  logic iordy = 1'b1;
  logic ack, err, dior_n, diow_n, cs0_n, cs1_n, dack_n, dd_oe;
  logic [15:0] rdata, dd_out;
  logic [2:0] da;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  ata_pio_dma_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup), .cfg_active(cfg_active),
    .cfg_recov(cfg_recov), .req(req), .req_wr(req_wr), .req_dma(req_dma),
    .req_cs(req_cs), .req_last(req_last), .req_addr(req_addr), .req_wdata(req_wdata),
    .ack(ack), .rdata(rdata), .err(err), .dior_n(dior_n), .diow_n(diow_n),
    .cs0_n(cs0_n), .cs1_n(cs1_n), .da(da), .dack_n(dack_n), .dd_out(dd_out),
    .dd_oe(dd_oe), .dd_in(dd_in), .iordy(iordy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // kwait: 0 = IORDY high, >0 = raise IORDY after that many strobe-low clocks, -1 = never
  task automatic run_cycle(input string wtag, input bit wr, input bit dma, input bit csel,
                           input bit last, input logic [2:0] addr, input logic [15:0] wd,
                           input int kwait, input int es, input int ea, input int er,
                           input bit eerr);
    int su = 0, ac = 0, rc = 0, ph = 0, guard = 0;
    bit selbad = 0, oebad = 0, sel_ok, strb;
    logic [15:0] base = 16'h5A00, got_rd;
    logic got_err;
    if (kwait != 0) iordy = 1'b0;
    req = 1; req_wr = wr; req_dma = dma; req_cs = csel; req_last = last;
    req_addr = addr; req_wdata = wd;
    while (1) begin
      @(negedge clk);
      guard++;
      if (ack || guard > 3000) break;
      if (dma) sel_ok = cs0_n && cs1_n && !dack_n && da == 3'd0;
      else sel_ok = (csel ? (!cs1_n && cs0_n) : (!cs0_n && cs1_n)) && dack_n && da == addr;
      if (!sel_ok) selbad = 1;
      if (wr ? !dior_n : !diow_n) selbad = 1;
      if (wr ? !(dd_oe && dd_out == wd) : dd_oe) oebad = 1;
      strb = wr ? !diow_n : !dior_n;
      if (strb) begin
        ph = 1; ac++;
        dd_in = base + 16'(ac);
        if (kwait > 0 && ac == kwait) iordy = 1'b1;
      end else if (ph == 0) su++;
      else rc++;
    end
    got_rd = rdata; got_err = err;
    req = 0; iordy = 1'b1;
    check(guard <= 3000, {wtag, " completion"}, guard, 0);
    check(su == es, "R3 setup clocks", su, es);
    check(ac == ea, wtag, ac, ea);
    check(rc == er, "R3 recovery clocks", rc, er);
    check(!selbad, dma ? "R7 dack select" : "R2 chip select", selbad, 0);
    check(!oebad, wr ? "R5 write data held" : "R4 bus not driven", oebad, 0);
    if (!wr) check(got_rd == base + 16'(ea), "R4 capture at strobe rise", got_rd, base + 16'(ea));
    check(got_err == eerr, "R9 error flag", got_err, eerr);
    @(negedge clk);
    check(!ack, "R10 ack pulse", ack, 0);
    check(dack_n == !(dma && !last), "R8 dack after word", dack_n, !(dma && !last));
  endtask

  task automatic t_reset();
    check(dior_n && diow_n && cs0_n && cs1_n && dack_n, "R1 bus idle in reset", 0, 1);
    check(!dd_oe && !ack && !err, "R1 no drive in reset", dd_oe, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(dior_n && diow_n && cs0_n && cs1_n && dack_n && !dd_oe && !ack, "R1 idle after reset", 0, 1);
  endtask

  task automatic t_pio_read();
    cfg_setup = 2; cfg_active = 3; cfg_recov = 2;
    run_cycle("R3 active width", 0, 0, 0, 0, 3'd5, 16'h0, 0, 2, 3, 2, 0);
  endtask

  task automatic t_pio_write();
    cfg_setup = 3; cfg_active = 2; cfg_recov = 1;
    run_cycle("R5 write width", 1, 0, 1, 0, 3'd2, 16'hC3A5, 0, 3, 2, 1, 0);
  endtask

  task automatic t_zero_cfg();
    cfg_setup = 0; cfg_active = 0; cfg_recov = 0;
    run_cycle("R3 zero counts", 0, 0, 1, 0, 3'd7, 16'h0, 0, 1, 1, 1, 0);
  endtask

  task automatic t_iordy();
    cfg_setup = 1; cfg_active = 3; cfg_recov = 1;
    run_cycle("R6 wait extends strobe", 0, 0, 0, 0, 3'd1, 16'h0, 5, 1, 7, 1, 0);
    run_cycle("R6 wait inside min width", 1, 0, 1, 0, 3'd4, 16'h1234, 1, 1, 3, 1, 0);
  endtask

  task automatic t_dma_burst();
    cfg_setup = 2; cfg_active = 2; cfg_recov = 2;
    run_cycle("R7 dma ignores iordy", 0, 1, 0, 0, 3'd6, 16'h0, -1, 2, 2, 2, 0);
    run_cycle("R8 burst word 2", 1, 1, 0, 0, 3'd6, 16'hBEEF, -1, 2, 2, 2, 0);
    run_cycle("R8 burst last word", 0, 1, 0, 1, 3'd6, 16'h0, 0, 2, 2, 2, 0);
  endtask

  task automatic t_timeout();
    cfg_setup = 1; cfg_active = 2; cfg_recov = 1;
    run_cycle("R9 timeout width", 0, 0, 0, 0, 3'd0, 16'h0, -1, 1, 1024, 1, 1);
    run_cycle("R9 normal after timeout", 0, 0, 1, 0, 3'd3, 16'h0, 0, 1, 2, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_pio_read();
    t_pio_write();
    t_zero_cfg();
    t_iordy();
    t_dma_burst();
    t_timeout();
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule